// File: doc/BRIEF.md
# Integer Execute Unit with Load Extender

This block is the integer execute stage of a 32-bit scalar core. Each cycle it may accept one operation, given as an operation code, two register operands, a 16-bit immediate, a 5-bit shift count and a 2-bit byte offset. It returns the result one clock later together with a write-back enable and an overflow-trap flag. It covers add and subtract in trapping and non-trapping forms, immediate add, the bitwise logic operations and their immediate forms, upper-immediate load, shifts by a fixed or a register-supplied count, and the sign or zero extension of byte and halfword load data.

The trapping and non-trapping add/subtract forms produce the same result bits. Only the trapping forms may report signed overflow. How an immediate is widened depends on the class of the operation and not on its name: the logic immediates are zero-filled, while both immediate adds are sign-extended. When overflow is reported the result is still presented, but it is marked as not to be written back.

Top module: `intx_unit`

## Requirements
- R1: Code values on `op_i` are: 0 add, 1 addu, 2 sub, 3 subu, 4 addi, 5 addiu, 6 and, 7 or, 8 xor, 9 nor, 10 andi, 11 ori, 12 xori, 13 lui, 14 sll, 15 srl, 16 sra, 17 sllv, 18 srlv, 19 srav, 20 lb, 21 lbu, 22 lh, 23 lhu. add/addu return `src_a_i + src_b_i` modulo 2^32, and sub/subu return `src_a_i - src_b_i` modulo 2^32. Trapping and non-trapping forms give identical result bits.
- R2: `ovf_q` is set for add and addi when both addends have the same sign and the sum's sign differs. It is set for sub when the operand signs differ and the difference's sign differs from `src_a_i`.
- R3: `ovf_q` is never set for any code other than add, sub and addi.
- R4: addi and addiu add `src_a_i` to `imm_i` sign-extended to 32 bits.
- R5: andi, ori and xori combine `src_a_i` with `imm_i` zero-extended to 32 bits.
- R6: lui returns `imm_i` in bits 31:16 with bits 15:0 cleared.
- R7: and, or, xor and nor apply the bitwise function to `src_a_i` and `src_b_i`. nor is the complement of or.
- R8: sll, srl and sra shift `src_b_i` by `shamt_i`. sllv, srlv and srav shift `src_b_i` by `src_a_i[4:0]`. sra and srav fill with bit 31 of `src_b_i`; the other shifts fill with zeros.
- R9: Loads take the word on `src_b_i`. A byte load picks bits 31:24, 23:16, 15:8 or 7:0 for `off_i` = 0, 1, 2 or 3. A halfword load picks bits 31:16 when `off_i[1]` is 0 and bits 15:0 when it is 1; `off_i[0]` is ignored. lb and lh sign-extend the selection; lbu and lhu zero-extend it.
- R10: Outputs are registered. An operation presented with `vld_i` high before a rising edge appears on `res_q`, `vld_q`, `wr_q` and `ovf_q` after that edge. `wr_q` is high for a valid, defined operation without overflow, and low whenever `ovf_q` is high. With `vld_i` low, the next `vld_q`, `wr_q`, `ovf_q` and `res_q` are all zero.
- R11: While `rst_ni` is low, all outputs are zero.
- R12: Codes 24 to 31 are undefined. They give `res_q` = 0, `wr_q` = 0 and `ovf_q` = 0, with `vld_q` still following `vld_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| src_a_i | input | 32 | First register operand |
| src_b_i | input | 32 | Second register operand, shift source, or load word |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Fixed shift count |
| off_i | input | 2 | Byte offset for sub-word loads |
| res_q | output | 32 | Registered result |
| vld_q | output | 1 | Registered valid |
| wr_q | output | 1 | Result may be written back |
| ovf_q | output | 1 | Overflow trap raised |

## Verification
The bench targets the sign boundaries of add and subtract, such as 0x7FFFFFFF plus one and 0x80000000 minus one. A design that trapped on the wrong forms, or used the wrong sign test for subtract, would set the trap flag or clear write-back on the wrong operation. Immediates with bit 15 set are sent to addiu and to the logic immediates, which exposes an extender keyed on the operation name instead of its class. Every byte offset is used for all four sub-word loads, and negative values are shifted arithmetically by both count sources, so a reversed lane order, a wrong fill bit or the wrong count source shows up directly in the result. Undefined codes and idle cycles check that nothing is marked for write-back.

// File: rtl/intx_pkg.sv
package intx_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
        OP_ADDI  = 5'd4,  OP_ADDIU = 5'd5,  OP_AND   = 5'd6,  OP_OR    = 5'd7,
        OP_XOR   = 5'd8,  OP_NOR   = 5'd9,  OP_ANDI  = 5'd10, OP_ORI   = 5'd11,
        OP_XORI  = 5'd12, OP_LUI   = 5'd13, OP_SLL   = 5'd14, OP_SRL   = 5'd15,
        OP_SRA   = 5'd16, OP_SLLV  = 5'd17, OP_SRLV  = 5'd18, OP_SRAV  = 5'd19,
        OP_LB    = 5'd20, OP_LBU   = 5'd21, OP_LH    = 5'd22, OP_LHU   = 5'd23
    } intx_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2, LG_NOR = 2'd3
    } intx_logic_e;

    typedef enum logic [1:0] {
        SH_LEFT = 2'd0, SH_RLOG = 2'd1, SH_RARI = 2'd2
    } intx_shift_e;

    function automatic logic op_may_trap(intx_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI);
    endfunction

endpackage

// File: rtl/intx_arith.sv
module intx_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    input  logic         sub_i,
    input  logic         trap_en_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    logic [W-1:0] sum_d;
    logic         sign_flip;

    always_comb begin
        sum_d = sub_i ? (lhs_i - rhs_i) : (lhs_i + rhs_i);
        if (sub_i) begin
            sign_flip = (lhs_i[W-1] != rhs_i[W-1]) && (sum_d[W-1] != lhs_i[W-1]);
        end else begin
            sign_flip = (lhs_i[W-1] == rhs_i[W-1]) && (sum_d[W-1] != lhs_i[W-1]);
        end
    end

    assign sum_o = sum_d;
    assign ovf_o = trap_en_i & sign_flip;
endmodule

// File: rtl/intx_logic_shift.sv
module intx_logic_shift
    import intx_pkg::*;
#(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  intx_logic_e    lfn_i,
    input  logic [W-1:0]   sh_src_i,
    input  logic [SHW-1:0] sh_amt_i,
    input  intx_shift_e    sfn_i,
    output logic [W-1:0]   logic_o,
    output logic [W-1:0]   shift_o
);
    always_comb begin
        unique case (lfn_i)
            LG_AND:  logic_o = a_i & b_i;
            LG_OR:   logic_o = a_i | b_i;
            LG_XOR:  logic_o = a_i ^ b_i;
            default: logic_o = ~(a_i | b_i);
        endcase
    end

    always_comb begin
        case (sfn_i)
            SH_LEFT: shift_o = sh_src_i << sh_amt_i;
            SH_RLOG: shift_o = sh_src_i >> sh_amt_i;
            default: shift_o = W'($signed(sh_src_i) >>> sh_amt_i);
        endcase
    end
endmodule

// File: rtl/intx_load_ext.sv
module intx_load_ext #(
    parameter int W = 32,
    localparam int NB   = W / 8,
    localparam int NH   = W / 16,
    localparam int OFFW = $clog2(NB)
) (
    input  logic [W-1:0]    word_i,
    input  logic [OFFW-1:0] off_i,
    input  logic            half_i,
    input  logic            sgn_i,
    output logic [W-1:0]    data_o
);
    logic [7:0]  byte_lane [NB];
    logic [15:0] half_lane [NH];

    // lane 0 sits at the most significant end (big-endian order)
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign byte_lane[i] = word_i[W-1-8*i -: 8];
    end
    for (genvar j = 0; j < NH; j++) begin : g_half
        assign half_lane[j] = word_i[W-1-16*j -: 16];
    end

    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b = byte_lane[off_i];
        sel_h = half_lane[off_i[OFFW-1:1]];
        if (half_i) begin
            data_o = {{(W-16){sgn_i & sel_h[15]}}, sel_h};
        end else begin
            data_o = {{(W-8){sgn_i & sel_b[7]}}, sel_b};
        end
    end
endmodule

// File: rtl/intx_unit.sv
module intx_unit
    import intx_pkg::*;
#(
    parameter int W    = 32,
    parameter int IMMW = 16,
    localparam int SHW  = $clog2(W),
    localparam int OFFW = $clog2(W / 8)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            vld_i,
    input  logic [4:0]      op_i,
    input  logic [W-1:0]    src_a_i,
    input  logic [W-1:0]    src_b_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic [SHW-1:0]  shamt_i,
    input  logic [OFFW-1:0] off_i,
    output logic [W-1:0]    res_q,
    output logic            vld_q,
    output logic            wr_q,
    output logic            ovf_q
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         vld;
        logic         wr;
        logic         ovf;
    } stage_t;

    stage_t   st_d, st_q;
    intx_op_e op_e;
    assign op_e = intx_op_e'(op_i);

    // operand preparation: immediates widened by operation class
    logic [W-1:0] imm_sx, imm_zx, imm_up;
    assign imm_sx = {{(W-IMMW){imm_i[IMMW-1]}}, imm_i};
    assign imm_zx = {{(W-IMMW){1'b0}}, imm_i};
    assign imm_up = {imm_i, {(W-IMMW){1'b0}}};

    logic         use_imm_arith, use_imm_logic, use_var_sh, do_sub, trap_en;
    logic         ld_half, ld_sgn;
    intx_logic_e  lfn;
    intx_shift_e  sfn;
    logic [W-1:0] ar_rhs, lg_rhs, ar_sum, lg_out, sh_out, ld_out;
    logic [SHW-1:0] sh_amt;
    logic         ar_ovf;

    always_comb begin
        use_imm_arith = (op_e == OP_ADDI) || (op_e == OP_ADDIU);
        use_imm_logic = (op_e == OP_ANDI) || (op_e == OP_ORI) || (op_e == OP_XORI);
        use_var_sh    = (op_e == OP_SLLV) || (op_e == OP_SRLV) || (op_e == OP_SRAV);
        do_sub        = (op_e == OP_SUB) || (op_e == OP_SUBU);
        trap_en       = op_may_trap(op_e);
        ld_half       = (op_e == OP_LH) || (op_e == OP_LHU);
        ld_sgn        = (op_e == OP_LB) || (op_e == OP_LH);
        ar_rhs        = use_imm_arith ? imm_sx : src_b_i;
        lg_rhs        = use_imm_logic ? imm_zx : src_b_i;
        sh_amt        = use_var_sh ? src_a_i[SHW-1:0] : shamt_i;
        case (op_e)
            OP_OR,  OP_ORI:  lfn = LG_OR;
            OP_XOR, OP_XORI: lfn = LG_XOR;
            OP_NOR:          lfn = LG_NOR;
            default:         lfn = LG_AND;
        endcase
        case (op_e)
            OP_SRL, OP_SRLV: sfn = SH_RLOG;
            OP_SRA, OP_SRAV: sfn = SH_RARI;
            default:         sfn = SH_LEFT;
        endcase
    end

    intx_arith #(.W(W)) u_arith (
        .lhs_i     (src_a_i),
        .rhs_i     (ar_rhs),
        .sub_i     (do_sub),
        .trap_en_i (trap_en),
        .sum_o     (ar_sum),
        .ovf_o     (ar_ovf)
    );

    intx_logic_shift #(.W(W)) u_lsh (
        .a_i      (src_a_i),
        .b_i      (lg_rhs),
        .lfn_i    (lfn),
        .sh_src_i (src_b_i),
        .sh_amt_i (sh_amt),
        .sfn_i    (sfn),
        .logic_o  (lg_out),
        .shift_o  (sh_out)
    );

    intx_load_ext #(.W(W)) u_ldx (
        .word_i (src_b_i),
        .off_i  (off_i),
        .half_i (ld_half),
        .sgn_i  (ld_sgn),
        .data_o (ld_out)
    );

    // next-state process
    always_comb begin
        logic [W-1:0] r;
        logic         legal;
        legal = 1'b1;
        case (op_e)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU, OP_ADDI, OP_ADDIU:   r = ar_sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR, OP_ANDI, OP_ORI, OP_XORI: r = lg_out;
            OP_LUI:                                                 r = imm_up;
            OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV:      r = sh_out;
            OP_LB, OP_LBU, OP_LH, OP_LHU:                           r = ld_out;
            default: begin
                r     = '0;
                legal = 1'b0;
            end
        endcase
        st_d     = '0;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.res = r;
            st_d.ovf = legal & ar_ovf;
            st_d.wr  = legal & ~ar_ovf;
        end
    end

    // register process
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q = st_q.res;
    assign vld_q = st_q.vld;
    assign wr_q  = st_q.wr;
    assign ovf_q = st_q.ovf;

    // only the three trapping codes may ever raise the flag
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_q |-> ($past(op_i) == 5'd0 || $past(op_i) == 5'd2 || $past(op_i) == 5'd4));

    p_ovf_blocks_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_q |-> (!wr_q && vld_q));

    p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vld_i |=> (!vld_q && !wr_q && !ovf_q));

    p_lui_low_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && op_i == 5'd13) |=> (res_q[W-IMMW-1:0] == '0));

    p_lbu_zero_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && op_i == 5'd21) |=> (res_q[W-1:8] == '0));

    p_undef_no_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && op_i > 5'd23) |=> (!wr_q && !ovf_q && res_q == '0));

    p_reset_clear_r11: assert property (@(posedge clk_i)
        !rst_ni |=> (!vld_q && !wr_q && !ovf_q && res_q == '0));
endmodule

// File: tb/intx_unit_bench.sv
`timescale 1ns/1ps
module intx_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] a = '0, b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  sh = '0;
    logic [1:0]  off = '0;
    logic [31:0] res_q;
    logic        vld_q, wr_q, ovf_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    intx_unit u_intx_unit (
        .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .op_i(op),
        .src_a_i(a), .src_b_i(b), .imm_i(imm), .shamt_i(sh), .off_i(off),
        .res_q(res_q), .vld_q(vld_q), .wr_q(wr_q), .ovf_q(ovf_q)
    );

    // expected {wr, ovf, res} from the requirements
    function automatic logic [33:0] expect_of(logic [4:0] o, logic [31:0] x, logic [31:0] y,
                                              logic [15:0] i, logic [4:0] s, logic [1:0] f);
        logic [31:0] r, isx, izx;
        logic [7:0]  bt;
        logic [15:0] hw;
        logic        v;
        isx = {{16{i[15]}}, i};
        izx = {16'h0, i};
        v = 1'b0;
        bt = y[31 - 8*f -: 8];
        hw = f[1] ? y[15:0] : y[31:16];
        case (o)
            0, 1:  begin r = x + y;   v = (o == 0) && (x[31] == y[31]) && (r[31] != x[31]); end
            2, 3:  begin r = x - y;   v = (o == 2) && (x[31] != y[31]) && (r[31] != x[31]); end
            4, 5:  begin r = x + isx; v = (o == 4) && (x[31] == isx[31]) && (r[31] != x[31]); end
            6:  r = x & y;
            7:  r = x | y;
            8:  r = x ^ y;
            9:  r = ~(x | y);
            10: r = x & izx;
            11: r = x | izx;
            12: r = x ^ izx;
            13: r = {i, 16'h0};
            14: r = y << s;
            15: r = y >> s;
            16: r = $signed(y) >>> s;
            17: r = y << x[4:0];
            18: r = y >> x[4:0];
            19: r = $signed(y) >>> x[4:0];
            20: r = {{24{bt[7]}}, bt};
            21: r = {24'h0, bt};
            22: r = {{16{hw[15]}}, hw};
            23: r = {16'h0, hw};
            default: r = 32'h0;
        endcase
        if (o > 23) return {1'b0, 1'b0, 32'h0};
        return {~v, v, r};
    endfunction

    function automatic string tag_of(logic [4:0] o);
        if (o <= 3)  return "R1";
        if (o <= 5)  return "R4";
        if (o <= 9)  return "R7";
        if (o <= 12) return "R5";
        if (o == 13) return "R6";
        if (o <= 19) return "R8";
        if (o <= 23) return "R9";
        return "R12";
    endfunction

    task automatic check(string tag, logic [34:0] act, logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%0d act vld/wr/ovf/res=%b/%b/%b/%h exp=%b/%b/%b/%h",
                     tag, op, act[34], act[33], act[32], act[31:0],
                     exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic run(string tag, logic [4:0] o, logic [31:0] x, logic [31:0] y,
                       logic [15:0] i, logic [4:0] s, logic [1:0] f);
        logic [33:0] e;
        @(negedge clk);
        vld = 1'b1; op = o; a = x; b = y; imm = i; sh = s; off = f;
        e = expect_of(o, x, y, i, s, f);
        @(negedge clk);
        check(tag, {vld_q, wr_q, ovf_q, res_q}, {1'b1, e});
        if (o != 0 && o != 2 && o != 4 && ovf_q) check("R3", {2'b0, ovf_q, 32'h0}, 35'h0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [4:0] ro;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        check("R11", {vld_q, wr_q, ovf_q, res_q}, 35'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 boundaries and R1 identical bits
        run("R2", 5'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 2'd0);
        run("R1", 5'd1, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 2'd0);
        run("R2", 5'd0, 32'h80000000, 32'h80000000, 16'h0, 5'd0, 2'd0);
        run("R2", 5'd2, 32'h80000000, 32'h1, 16'h0, 5'd0, 2'd0);
        run("R3", 5'd3, 32'h80000000, 32'h1, 16'h0, 5'd0, 2'd0);
        run("R2", 5'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0, 2'd0);
        run("R2", 5'd2, 32'h00000000, 32'h80000000, 16'h0, 5'd0, 2'd0);
        run("R2", 5'd4, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, 2'd0);
        run("R2", 5'd4, 32'h80000000, 32'h0, 16'hFFFF, 5'd0, 2'd0);
        run("R4", 5'd5, 32'h80000000, 32'h0, 16'hFFFF, 5'd0, 2'd0);
        run("R4", 5'd5, 32'h00000010, 32'h0, 16'h8000, 5'd0, 2'd0);
        run("R5", 5'd10, 32'hFFFFFFFF, 32'h0, 16'h8001, 5'd0, 2'd0);
        run("R5", 5'd11, 32'h00000000, 32'h0, 16'hF00F, 5'd0, 2'd0);
        run("R5", 5'd12, 32'hFFFF0000, 32'h0, 16'hFFFF, 5'd0, 2'd0);
        run("R6", 5'd13, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hBEEF, 5'd0, 2'd0);
        run("R7", 5'd9, 32'h0F0F0F0F, 32'h00FF00FF, 16'h0, 5'd0, 2'd0);
        run("R8", 5'd16, 32'h0, 32'h80000010, 16'h0, 5'd31, 2'd0);
        run("R8", 5'd19, 32'hFFFFFFE4, 32'h80000010, 16'h0, 5'd9, 2'd0);
        run("R8", 5'd18, 32'h00000004, 32'h80000010, 16'h0, 5'd0, 2'd0);
        run("R8", 5'd14, 32'h0, 32'h00000001, 16'h0, 5'd31, 2'd0);
        for (int k = 0; k < 4; k++) begin
            for (int t = 20; t < 24; t++) begin
                run("R9", 5'(t), 32'h0, 32'h8A7B96C5, 16'h0, 5'd0, 2'(k));
            end
        end
        run("R12", 5'd24, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 2'd0);
        run("R12", 5'd31, 32'h12345678, 32'h1, 16'h0, 5'd0, 2'd0);

        // R10: idle cycle after an overflowing op gives a quiet output
        @(negedge clk);
        vld = 1'b0; op = 5'd0; a = 32'h7FFFFFFF; b = 32'h1;
        @(negedge clk);
        check("R10", {vld_q, wr_q, ovf_q, res_q}, 35'h0);

        for (int n = 0; n < 4000; n++) begin
            ro = 5'($urandom_range(0, 25));
            run(tag_of(ro), ro, $urandom, $urandom, 16'($urandom), 5'($urandom), 2'($urandom));
        end

        // R11: reset mid-stream clears outputs
        @(negedge clk);
        rst_n = 1'b0; vld = 1'b1; op = 5'd1; a = 32'h5; b = 32'h6;
        @(negedge clk);
        check("R11", {vld_q, wr_q, ovf_q, res_q}, 35'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule